// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a data cache placed between a processor and a main memory that takes several cycles to answer. Each processor address maps to exactly one cache entry. Each entry keeps a tag, a valid flag, a dirty flag and a line of several words. Stores stay in the cache and reach memory only when their line is displaced. A store that misses first brings the whole line in and then merges the store word into it.

The processor offers a request with a valid/ready handshake. A request carries an address, a read/write flag and store data. Load data comes back on a one-cycle response strobe. Stores produce no response. On the memory side the cache issues whole-line read and write requests through a valid/ready handshake. Refill lines come back on a response strobe after any number of cycles.

The cache is blocking. Once a miss is accepted, `req_ready` stays low until the refill has been installed. At most one eviction and one refill are in flight at any time.

Top module: `dm_wb_cache`

## Requirements
- R1: With default parameters the request address splits as tag = bits [31:8], line index = bits [7:4], word select = bits [3:2]. Bits [1:0] are ignored. Neighbouring line addresses therefore occupy different entries, and both stay resident together.
- R2: A load that hits returns the stored word with `rsp_valid` high in the cycle after the request is accepted. It issues no memory request.
- R3: A store that hits updates only the cached word and marks the entry dirty. It issues no memory request and raises no `rsp_valid`.
- R4: On a miss whose victim entry is invalid or clean, the cache issues one line read (`mem_req_write` = 0) at the line-aligned address: word and byte bits zero.
- R5: On a miss whose victim is valid and dirty, the cache first issues a line write (`mem_req_write` = 1) carrying the victim's full line at the victim's line address. The line read follows only after that write has been accepted.
- R6: On a store miss, the refilled line is installed with the store word merged at its word position and is marked dirty. A later eviction writes back this merged line.
- R7: On a load miss, the requested word from the refill line appears with `rsp_valid` in the cycle after `mem_rsp_valid`. In that same cycle `req_ready` returns high.
- R8: From the acceptance of a miss until the refill is installed, `req_ready` stays low and no request is taken.
- R9: Reset clears every valid and dirty flag. The first access to any address after reset misses and causes no write-back.
- R10: A memory request that is not accepted keeps `mem_req_valid`, address, write flag and line data unchanged until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (32) | Byte address of the access |
| req_wdata | input | WORD_W (32) | Store word |
| rsp_valid | output | 1 | Load data valid strobe |
| rsp_rdata | output | WORD_W (32) | Load data |
| mem_req_valid | output | 1 | Line request to memory present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | ADDR_W (32) | Line-aligned memory address |
| mem_req_wdata | output | WORD_W*WORDS_PER_LINE (128) | Line being written back |
| mem_rsp_valid | input | 1 | Refill line present |
| mem_rsp_rdata | input | WORD_W*WORDS_PER_LINE (128) | Refill line |

## Verification
The bench first reads address zero right after reset. A design that left valid flags set would report a false hit against the reset tags. It then forces a dirty entry out by a tag conflict on the same index. A design that skipped the write-back, sent it after the refill, or wrote the wrong victim address would show a memory request that does not match the model. A store miss is followed by a read of the merged word and then an eviction of that line. This exposes a refill that drops the store word or forgets to set dirty. Memory acceptance is stalled for several cycles throughout, to catch a request that changes while waiting or a `req_ready` that rises before the refill lands.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_WBACK = 2'd1,
        ST_FREQ  = 2'd2,
        ST_FWAIT = 2'd3
    } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W    = 32,
    parameter int BYTE_BITS = 2,
    parameter int WOFF_W    = 2,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [WOFF_W-1:0] woff
);
    localparam int IDX_LO = BYTE_BITS + WOFF_W;
    localparam int TAG_LO = IDX_LO + IDX_W;

    // byte bits below the word are deliberately left unused
    logic [BYTE_BITS-1:0] unused_byte;
    assign unused_byte = addr[BYTE_BITS-1:0];

    assign woff = addr[BYTE_BITS +: WOFF_W];
    assign idx  = addr[IDX_LO +: IDX_W];
    assign tag  = addr[TAG_LO +: TAG_W];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int LINES = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty
);
    logic [TAG_W-1:0] tag_q   [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tag_q[g]   <= '0;
                    valid_q[g] <= 1'b0;
                    dirty_q[g] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    tag_q[g]   <= wr_tag;
                    valid_q[g] <= 1'b1;
                    dirty_q[g] <= wr_dirty;
                end
            end
        end
    endgenerate

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int LINES  = 16,
    parameter int IDX_W  = 4,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] line_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_LINE = 4,
    parameter int LINES          = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic                             req_write,
    input  logic [ADDR_W-1:0]                req_addr,
    input  logic [WORD_W-1:0]                req_wdata,
    output logic                             rsp_valid,
    output logic [WORD_W-1:0]                rsp_rdata,
    output logic                             mem_req_valid,
    input  logic                             mem_req_ready,
    output logic                             mem_req_write,
    output logic [ADDR_W-1:0]                mem_req_addr,
    output logic [WORD_W*WORDS_PER_LINE-1:0] mem_req_wdata,
    input  logic                             mem_rsp_valid,
    input  logic [WORD_W*WORDS_PER_LINE-1:0] mem_rsp_rdata
);
    localparam int BYTE_BITS = $clog2(WORD_W / 8);
    localparam int WOFF_W    = $clog2(WORDS_PER_LINE);
    localparam int IDX_W     = $clog2(LINES);
    localparam int LOW_W     = BYTE_BITS + WOFF_W;
    localparam int TAG_W     = ADDR_W - IDX_W - LOW_W;
    localparam int LINE_W    = WORD_W * WORDS_PER_LINE;

    typedef struct packed {
        dmc_state_e        state;
        logic [ADDR_W-1:0] p_addr;
        logic              p_write;
        logic [WORD_W-1:0] p_wdata;
        logic              rsp_valid;
        logic [WORD_W-1:0] rsp_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [TAG_W-1:0]  req_tag, p_tag, rd_tag, wr_tag;
    logic [IDX_W-1:0]  req_idx, p_idx, rd_idx, wr_idx;
    logic [WOFF_W-1:0] req_woff, p_woff;
    logic              rd_valid, rd_dirty, hit;
    logic              tag_wr_en, data_wr_en, wr_dirty;
    logic [LINE_W-1:0] rd_line, wr_line;

    function automatic logic [LINE_W-1:0] merge_word(
        input logic [LINE_W-1:0] line,
        input logic [WOFF_W-1:0] sel,
        input logic [WORD_W-1:0] word
    );
        logic [LINE_W-1:0] res;
        res = line;
        for (int w = 0; w < WORDS_PER_LINE; w++) begin
            if (sel == WOFF_W'(w)) begin
                res[w*WORD_W +: WORD_W] = word;
            end
        end
        return res;
    endfunction

    function automatic logic [WORD_W-1:0] pick_word(
        input logic [LINE_W-1:0] line,
        input logic [WOFF_W-1:0] sel
    );
        logic [WORD_W-1:0] res;
        res = '0;
        for (int w = 0; w < WORDS_PER_LINE; w++) begin
            if (sel == WOFF_W'(w)) begin
                res = line[w*WORD_W +: WORD_W];
            end
        end
        return res;
    endfunction

    dmc_addr_split #(
        .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .WOFF_W(WOFF_W),
        .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_req_split (
        .addr(req_addr), .tag(req_tag), .idx(req_idx), .woff(req_woff)
    );

    dmc_addr_split #(
        .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .WOFF_W(WOFF_W),
        .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_pend_split (
        .addr(r_q.p_addr), .tag(p_tag), .idx(p_idx), .woff(p_woff)
    );

    // lookup follows the live request when idle, the pending miss otherwise
    assign rd_idx = (r_q.state == ST_READY) ? req_idx : p_idx;

    dmc_tag_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .wr_en(tag_wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_dirty(wr_dirty)
    );

    dmc_line_store #(
        .LINES(LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)
    ) u_lines (
        .clk(clk),
        .rd_idx(rd_idx), .rd_line(rd_line),
        .wr_en(data_wr_en), .wr_idx(wr_idx), .wr_line(wr_line)
    );

    assign hit = rd_valid && (rd_tag == req_tag);

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        tag_wr_en     = 1'b0;
        data_wr_en    = 1'b0;
        wr_idx        = p_idx;
        wr_tag        = p_tag;
        wr_dirty      = 1'b0;
        wr_line       = rd_line;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = rd_line;

        case (r_q.state)
            ST_READY: begin
                if (req_valid) begin
                    if (hit) begin
                        if (req_write) begin
                            tag_wr_en  = 1'b1;
                            data_wr_en = 1'b1;
                            wr_idx     = req_idx;
                            wr_tag     = req_tag;
                            wr_dirty   = 1'b1;
                            wr_line    = merge_word(rd_line, req_woff, req_wdata);
                        end else begin
                            r_d.rsp_valid = 1'b1;
                            r_d.rsp_data  = pick_word(rd_line, req_woff);
                        end
                    end else begin
                        r_d.p_addr  = req_addr;
                        r_d.p_write = req_write;
                        r_d.p_wdata = req_wdata;
                        r_d.state   = (rd_valid && rd_dirty) ? ST_WBACK : ST_FREQ;
                    end
                end
            end
            ST_WBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {rd_tag, p_idx, {LOW_W{1'b0}}};
                if (mem_req_ready) begin
                    r_d.state = ST_FREQ;
                end
            end
            ST_FREQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {p_tag, p_idx, {LOW_W{1'b0}}};
                if (mem_req_ready) begin
                    r_d.state = ST_FWAIT;
                end
            end
            ST_FWAIT: begin
                if (mem_rsp_valid) begin
                    tag_wr_en  = 1'b1;
                    data_wr_en = 1'b1;
                    wr_dirty   = r_q.p_write;
                    wr_line    = r_q.p_write
                               ? merge_word(mem_rsp_rdata, p_woff, r_q.p_wdata)
                               : mem_rsp_rdata;
                    if (!r_q.p_write) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_data  = pick_word(mem_rsp_rdata, p_woff);
                    end
                    r_d.state = ST_READY;
                end
            end
            default: r_d.state = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_READY);
    assign rsp_valid = r_q.rsp_valid;
    assign rsp_rdata = r_q.rsp_data;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W         = 32,
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_LINE = 4,
    parameter int LINES          = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             req_valid,
    input logic                             req_ready,
    input logic                             req_write,
    input logic                             rsp_valid,
    input logic                             mem_req_valid,
    input logic                             mem_req_ready,
    input logic                             mem_req_write,
    input logic [ADDR_W-1:0]                mem_req_addr,
    input logic [WORD_W*WORDS_PER_LINE-1:0] mem_req_wdata,
    input logic                             mem_rsp_valid
);
    localparam int LOW_W = $clog2(WORD_W / 8) + $clog2(WORDS_PER_LINE);
    localparam int ENTRY_COUNT = LINES;

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

    assert_blocking_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    assert_wb_then_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && mem_req_write) |=> (mem_req_valid && !mem_req_write));

    assert_line_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[LOW_W-1:0] == '0));

    assert_rsp_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past((req_valid && req_ready && !req_write) || mem_rsp_valid));

    assert_store_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !rsp_valid);
endmodule

bind dm_wb_cache dmc_checker #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS_PER_LINE(WORDS_PER_LINE), .LINES(LINES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/tb_dm_wb_cache.sv
`timescale 1ns/1ps
module tb_dm_wb_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [31:0]  req_addr = '0, req_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
    logic [31:0]  mem_req_addr;
    logic [127:0] mem_req_wdata;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_rdata = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [127:0] bmem [logic [31:0]];
    logic [23:0]  mtag   [16];
    bit           mvalid [16];
    bit           mdirty [16];
    logic [127:0] mdata  [16];

    always #5 clk = ~clk;

    dm_wb_cache dut (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mem_line(input logic [31:0] la);
        logic [127:0] l;
        if (bmem.exists(la)) return bmem[la];
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = (la + 32'(w * 4)) ^ 32'hC0DE_0000;
        return l;
    endfunction

    task automatic wait_accept(input string req);
        int stall;
        stall = 0;
        while (!mem_req_ready) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R8", req_ready, 0);
            stall++;
            if (stall == 3) mem_req_ready = 1'b1;
        end
        @(negedge clk);
        mem_req_ready = 1'b0;
    endtask

    task automatic do_req(input bit wr, input logic [31:0] a, input logic [31:0] wd, input int lat);
        logic [3:0]   idx;
        logic [23:0]  tag;
        int           wo;
        bit           hit;
        logic [127:0] fill, exp_line;
        logic [31:0]  exp_word;
        logic [31:0]  wb_addr, rd_addr;
        logic [127:0] wb_line;
        idx = a[7:4];
        tag = a[31:8];
        wo  = int'(a[3:2]);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        hit = mvalid[idx] && (mtag[idx] == tag);
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) begin
            chk(mem_req_valid == 1'b0, wr ? "R3" : "R2", mem_req_valid, 0);
            chk(rsp_valid == !wr, wr ? "R3" : "R2", rsp_valid, !wr);
            if (!wr) chk(rsp_rdata == mdata[idx][wo*32 +: 32], "R2 R1", rsp_rdata, mdata[idx][wo*32 +: 32]);
            if (wr) begin
                mdata[idx][wo*32 +: 32] = wd;
                mdirty[idx] = 1'b1;
            end
            return;
        end
        chk(req_ready == 1'b0, "R8", req_ready, 0);
        chk(rsp_valid == 1'b0, "R7", rsp_valid, 0);
        if (mvalid[idx] && mdirty[idx]) begin
            wb_addr = {mtag[idx], idx, 4'h0};
            wb_line = mdata[idx];
            chk(mem_req_valid && mem_req_write, "R5", {mem_req_valid, mem_req_write}, 2'b11);
            chk(mem_req_addr == wb_addr, "R5", mem_req_addr, wb_addr);
            chk(mem_req_wdata == wb_line, "R5 R6", mem_req_wdata, wb_line);
            repeat (2) begin
                @(negedge clk);
                chk(mem_req_valid && mem_req_write && mem_req_addr == wb_addr && mem_req_wdata == wb_line,
                    "R10", mem_req_addr, wb_addr);
            end
            mem_req_ready = 1'b1;
            wait_accept("R5");
            bmem[wb_addr] = wb_line;
        end
        rd_addr = {tag, idx, 4'h0};
        chk(mem_req_valid && !mem_req_write, wr ? "R6" : "R4", {mem_req_valid, mem_req_write}, 2'b10);
        chk(mem_req_addr == rd_addr, "R4", mem_req_addr, rd_addr);
        @(negedge clk);
        chk(mem_req_valid && !mem_req_write && mem_req_addr == rd_addr, "R10", mem_req_addr, rd_addr);
        mem_req_ready = 1'b1;
        wait_accept("R4");
        chk(mem_req_valid == 1'b0, "R4", mem_req_valid, 0);
        repeat (lat) begin
            @(negedge clk);
            chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R8", {req_ready, rsp_valid}, 0);
        end
        fill = mem_line(rd_addr);
        mem_rsp_valid = 1'b1; mem_rsp_rdata = fill;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(req_ready == 1'b1, "R7 R8", req_ready, 1);
        chk(rsp_valid == !wr, wr ? "R6" : "R7", rsp_valid, !wr);
        exp_word = fill[wo*32 +: 32];
        if (!wr) chk(rsp_rdata == exp_word, "R7", rsp_rdata, exp_word);
        exp_line = fill;
        if (wr) exp_line[wo*32 +: 32] = wd;
        mtag[idx] = tag; mvalid[idx] = 1'b1; mdirty[idx] = wr; mdata[idx] = exp_line;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mvalid[i] = 1'b0; mdirty[i] = 1'b0; mtag[i] = '0; mdata[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0 || req_ready == 1'b1, "R9", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R9",
            {req_ready, rsp_valid, mem_req_valid}, 3'b100);
        do_req(0, 32'h0000_0000, 0, 2);           // R9: tag zero must still miss
        do_req(0, 32'h0000_0100, 0, 4);           // R4: clean victim, no write-back
        do_req(0, 32'h0000_0104, 0, 0);           // R2: hit word 1
        do_req(0, 32'h0000_010F, 0, 0);           // R1: byte bits ignored, word 3
        do_req(1, 32'h0000_0108, 32'hDEAD_BEEF, 0); // R3: store hit
        do_req(0, 32'h0000_0108, 0, 0);           // R3: reads the stored word
        do_req(0, 32'h0000_0110, 0, 1);           // R1: adjacent line, other index
        do_req(0, 32'h0000_0100, 0, 0);           // R1: both lines resident
        do_req(0, 32'h0001_0100, 0, 3);           // R5: dirty victim written back
        do_req(1, 32'h0000_2204, 32'h1234_5678, 5); // R6: store miss merges
        do_req(0, 32'h0000_2204, 0, 0);           // R6: merged word hits
        do_req(0, 32'h0000_2200, 0, 0);           // R6: other words from memory
        do_req(0, 32'h0003_0200, 0, 2);           // R6 R5: merged line evicted
        do_req(0, 32'h0000_2204, 0, 1);           // R6: merged data reached memory
        do_req(1, 32'h0000_0114, 32'hA5A5_0001, 0); // R3: store hit on index 1
        do_req(0, 32'h0000_0310, 0, 2);           // R5: second index evicts dirty line
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule